// File: doc/BRIEF.md
# Bus Write-Hit Test Target

This block is a small register target that sits behind two address windows: a memory-type window and an I/O-type window. A host selects one of three tests by writing a test number to byte 0 of either window. The window that receives this write sets the region type. The block then publishes a little-endian header. The header gives the chosen test index, an access width, a target offset and a data byte. It also holds a running count of qualifying writes and a short zero-terminated ASCII name.

The host writes to the target offset and reads the count back to confirm that its writes arrived. Every register access is one byte wide. A read returns one header byte, one cycle after the read strobe. Only one test is live at a time, so the header and count are shared by both windows.

Control is a two-state machine. `ST_IDLE` means no test is active. `ST_RUN` means a test is active. A select write carrying a value from 0 to 2 takes either state to `ST_RUN`, which is the transition *select-go*. A select write carrying 3 or more takes either state to `ST_IDLE`, which is *select-stop*. Reset forces `ST_IDLE`.

Top module: `hit_target`

## Requirements
- R1: After synchronous reset (`rst` high) no test is active, `bus_rdata` is 0, and every read returns 0.
- R2: A write to address 0 inside the window first stops any active test. If the value is 0, 1 or 2, test index = region*3 + value becomes active (region 0 = memory, region 1 = I/O) and its count is cleared to 0. If the value is 3 or more, no test is active afterwards.
- R3: Header bytes of the active test: byte 0 = index, byte 1 = 1, bytes 2-3 = 0, bytes 4-7 = target offset (little endian), byte 8 = data byte, bytes 9-11 = 0, bytes 12-15 = count (little endian), bytes 16 onward = name followed by a 0 byte.
- R4: The target offset is 2048+i for memory tests (i = 0..2) and 128+i for I/O tests (i = 3..5). The test kind is i mod 3. The data byte is 0xCE for kind 1 and 0xFA for kinds 0 and 2.
- R5: For kind 1, any write to the target offset increments the count, whatever its size or value.
- R6: For kinds 0 and 2, a write to the target offset increments the count only when the access size is 1 and the written value equals the data byte.
- R7: Writes to any other address are ignored. No write is counted while no test is active. The header and count are reachable through either window, and matching compares the address only.
- R8: A read that hits while a test is active returns exactly one header byte, on the cycle after `bus_rd`. If address + size >= 17 + name length, the read returns 0 instead, so the terminator byte itself reads as 0.
- R9: The memory window decodes 4096 bytes and the I/O window decodes 256 bytes. An I/O access at address 256 or above is ignored: a write changes nothing and a read returns 0.
- R10: Test names by index 0..5: "mem-plain", "mem-anydata", "mem-exact", "io-plain", "io-anydata", "io-exact".
- R11: Each qualifying write adds exactly 1 to the count, and the count wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_region | input | 1 | Window of the access: 0 memory, 1 I/O |
| bus_addr | input | ADDR_W | Byte address within the window |
| bus_size | input | 3 | Access size in bytes (1, 2 or 4) |
| bus_wdata | input | 8 | Write value |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, registered, valid the cycle after `bus_rd` |

## Verification
The assertions assume that `bus_wr` and `bus_rd` are never high in the same cycle. They also assume that `bus_size` is 1, 2 or 4. Under those assumptions the count can only step by one or be cleared by a select write, and a read can only return 0 when idle. The stimulus drives one strobe per operation and draws sizes only from that set. It biases addresses toward byte 0, the current target offset, the header area and the I/O window edge. It biases write values toward 0-3, 0xFA and 0xCE.

// File: rtl/ht_pkg.sv
`timescale 1ns/1ps
package ht_pkg;

    localparam int NUM_KINDS  = 3;
    localparam int HDR_FIXED  = 16;
    localparam int NAME_MAX   = 12;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } ht_state_e;

    typedef enum logic [1:0] {
        KIND_PLAIN = 2'd0,
        KIND_ANY   = 2'd1,
        KIND_EXACT = 2'd2
    } ht_kind_e;

    function automatic ht_kind_e kind_of(input logic [2:0] idx);
        logic [2:0] k;
        k = (idx >= 3'(NUM_KINDS)) ? idx - 3'(NUM_KINDS) : idx;
        return ht_kind_e'(k[1:0]);
    endfunction

    function automatic logic [7:0] kind_data(input ht_kind_e k);
        return (k == KIND_ANY) ? 8'hCE : 8'hFA;
    endfunction

    // Name strings, left-aligned and zero padded to NAME_MAX bytes
    function automatic logic [8*NAME_MAX-1:0] name_str(input logic [2:0] idx);
        logic [8*NAME_MAX-1:0] s;
        unique case (idx)
            3'd0:    s = {"mem-plain",   24'h0};
            3'd1:    s = {"mem-anydata",  8'h0};
            3'd2:    s = {"mem-exact",   24'h0};
            3'd3:    s = {"io-plain",    32'h0};
            3'd4:    s = {"io-anydata",  16'h0};
            3'd5:    s = {"io-exact",    32'h0};
            default: s = '0;
        endcase
        return s;
    endfunction

    function automatic int name_len(input logic [2:0] idx);
        int n;
        unique case (idx)
            3'd0:    n = 9;
            3'd1:    n = 11;
            3'd2:    n = 9;
            3'd3:    n = 8;
            3'd4:    n = 10;
            3'd5:    n = 8;
            default: n = 0;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/ht_hdr_view.sv
`timescale 1ns/1ps
module ht_hdr_view #(
    parameter int ADDR_W   = 12,
    parameter int CNT_W    = 32,
    parameter int MEM_BASE = 2048,
    parameter int IO_BASE  = 128
) (
    input  logic [2:0]        idx_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [2:0]        size_i,
    output logic [31:0]       target_o,
    output logic [7:0]        data_o,
    output logic              fits_o,
    output logic [7:0]        byte_o
);
    import ht_pkg::*;

    localparam int LEN_W = ADDR_W + 1;

    logic [31:0]           cnt32;
    logic [7:0]            fixed_b [HDR_FIXED];
    logic [8*NAME_MAX-1:0] nm;
    logic [ADDR_W-1:0]     pos;
    logic [7:0]            name_b;

    assign cnt32    = 32'(cnt_i);
    assign target_o = (idx_i < 3'(NUM_KINDS)) ? 32'(MEM_BASE) + 32'(idx_i)
                                              : 32'(IO_BASE) + 32'(idx_i);
    assign data_o   = kind_data(kind_of(idx_i));
    assign fits_o   = ({1'b0, addr_i} + LEN_W'(size_i))
                      < LEN_W'(HDR_FIXED + 1 + name_len(idx_i));

    // Fixed part of the header, one generated lane per byte position
    for (genvar b = 0; b < HDR_FIXED; b++) begin : g_fixed
        if (b == 0) begin : g_idx
            assign fixed_b[b] = {5'd0, idx_i};
        end else if (b == 1) begin : g_width
            assign fixed_b[b] = 8'd1;
        end else if (b >= 4 && b < 8) begin : g_off
            assign fixed_b[b] = target_o[8*(b-4) +: 8];
        end else if (b == 8) begin : g_data
            assign fixed_b[b] = data_o;
        end else if (b >= 12) begin : g_cnt
            assign fixed_b[b] = cnt32[8*(b-12) +: 8];
        end else begin : g_pad
            assign fixed_b[b] = 8'd0;
        end
    end

    assign nm  = name_str(idx_i);
    assign pos = addr_i - ADDR_W'(HDR_FIXED);

    always_comb begin
        name_b = 8'd0;
        if (int'(pos) < NAME_MAX) begin
            name_b = nm[(NAME_MAX - 1 - int'(pos))*8 +: 8];
        end
    end

    assign byte_o = (addr_i < ADDR_W'(HDR_FIXED)) ? fixed_b[addr_i[3:0]] : name_b;

endmodule

// File: rtl/ht_hit_match.sv
`timescale 1ns/1ps
module ht_hit_match #(
    parameter int ADDR_W = 12
) (
    input  logic              active_i,
    input  logic              wr_i,
    input  logic              win_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [2:0]        size_i,
    input  logic [7:0]        wdata_i,
    input  logic [31:0]       target_i,
    input  logic [7:0]        data_i,
    input  logic [2:0]        idx_i,
    output logic              hit_o
);
    import ht_pkg::*;

    logic     at_target;
    logic     exact_ok;
    ht_kind_e kind;

    assign kind      = kind_of(idx_i);
    assign at_target = (32'(addr_i) == target_i);
    assign exact_ok  = (size_i == 3'd1) && (wdata_i == data_i);

    always_comb begin
        hit_o = 1'b0;
        if (active_i && wr_i && win_i && at_target) begin
            unique case (kind)
                KIND_ANY:   hit_o = 1'b1;
                KIND_PLAIN: hit_o = exact_ok;
                KIND_EXACT: hit_o = exact_ok;
                default:    hit_o = 1'b0;
            endcase
        end
    end

    // R6
    always_comb begin
        if (hit_o && kind != KIND_ANY) begin
            exact_hit_chk: assert (size_i == 3'd1 && wdata_i == data_i);
        end
    end

endmodule

// File: rtl/hit_target.sv
`timescale 1ns/1ps
module hit_target #(
    parameter int ADDR_W   = 12,
    parameter int CNT_W    = 32,
    parameter int MEM_BASE = 2048,
    parameter int IO_BASE  = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_region,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [2:0]        bus_size,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [7:0]        bus_rdata
);
    import ht_pkg::*;

    localparam int NUM_REGIONS = 2;

    ht_state_e        state_q, state_d;
    logic [2:0]       idx_q;
    logic [CNT_W-1:0] cnt_q;
    logic [1:0]       win_ok;
    logic             in_win;
    logic             sel_wr, sel_go;
    logic [2:0]       new_idx;
    logic [31:0]      target;
    logic [7:0]       data_b;
    logic             fits;
    logic [7:0]       hdr_b;
    logic             hit;
    logic             active;

    // Window decode: memory spans 2*MEM_BASE, I/O spans 2*IO_BASE
    for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_win
        localparam int SPAN = (r == 0) ? 2 * MEM_BASE : 2 * IO_BASE;
        assign win_ok[r] = ({1'b0, bus_addr} < (ADDR_W+1)'(SPAN));
    end

    assign in_win  = win_ok[bus_region];
    assign active  = (state_q == ST_RUN);
    assign sel_wr  = bus_wr && in_win && (bus_addr == '0);
    assign sel_go  = sel_wr && (bus_wdata < 8'(NUM_KINDS));
    assign new_idx = (bus_region ? 3'(NUM_KINDS) : 3'd0) + {1'b0, bus_wdata[1:0]};

    ht_hdr_view #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W), .MEM_BASE(MEM_BASE), .IO_BASE(IO_BASE)
    ) u_view (
        .idx_i(idx_q), .cnt_i(cnt_q), .addr_i(bus_addr), .size_i(bus_size),
        .target_o(target), .data_o(data_b), .fits_o(fits), .byte_o(hdr_b)
    );

    ht_hit_match #(.ADDR_W(ADDR_W)) u_match (
        .active_i(active), .wr_i(bus_wr && !sel_wr), .win_i(in_win),
        .addr_i(bus_addr), .size_i(bus_size), .wdata_i(bus_wdata),
        .target_i(target), .data_i(data_b), .idx_i(idx_q), .hit_o(hit)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (sel_wr) state_d = sel_go ? ST_RUN : ST_IDLE;
            ST_RUN:  if (sel_wr) state_d = sel_go ? ST_RUN : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // Outputs and datapath registers
    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q     <= 3'd0;
            cnt_q     <= '0;
            bus_rdata <= 8'd0;
        end else begin
            if (sel_go) begin
                idx_q <= new_idx;
                cnt_q <= '0;
            end else if (hit) begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (bus_rd) begin
                bus_rdata <= (active && in_win && fits) ? hdr_b : 8'd0;
            end
        end
    end

    // R2
    sel_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && in_win && bus_addr == '0 && bus_wdata >= 8'd3) |=> !active);

    // R2
    sel_go_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && in_win && bus_addr == '0 && bus_wdata < 8'd3) |=> (active && cnt_q == '0));

    // R11
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(sel_go) |-> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1));

    // R7
    cnt_src_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(sel_go) && cnt_q != $past(cnt_q)) |-> ($past(bus_wr) && $past(active)));

    // R1
    rd_idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !active) |=> (bus_rdata == 8'd0));

    // R9
    io_win_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_region && 32'(bus_addr) >= 32'(2*IO_BASE)) |=> $stable(cnt_q));

endmodule

// File: tb/sim_hit_target.sv
`timescale 1ns/1ps
module sim_hit_target;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_region = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [2:0]  bus_size = 3'd1;
    logic [7:0]  bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_rdata;

    int n_cmp = 0;
    int n_bad = 0;

    // bench model
    bit          m_act = 0;
    int          m_idx = 0;
    logic [31:0] m_cnt = '0;

    always #4 clk = ~clk;

    hit_target u0 (
        .clk(clk), .rst(rst), .bus_region(bus_region), .bus_addr(bus_addr),
        .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_rdata(bus_rdata)
    );

    function automatic string exp_name(int i);
        case (i)
            0: return "mem-plain";
            1: return "mem-anydata";
            2: return "mem-exact";
            3: return "io-plain";
            4: return "io-anydata";
            default: return "io-exact";
        endcase
    endfunction

    function automatic int exp_off(int i);
        return (i < 3) ? 2048 + i : 128 + i;
    endfunction

    function automatic logic [7:0] exp_data(int i);
        return ((i % 3) == 1) ? 8'hCE : 8'hFA;
    endfunction

    function automatic logic [7:0] exp_byte(bit reg_, int a, int sz);
        string nm;
        logic [31:0] off;
        if (reg_ && a >= 256) return 8'd0;
        if (!m_act) return 8'd0;
        nm = exp_name(m_idx);
        if (a + sz >= 17 + nm.len()) return 8'd0;
        off = 32'(exp_off(m_idx));
        if (a == 0) return 8'(m_idx);
        if (a == 1) return 8'd1;
        if (a >= 4 && a < 8) return off[8*(a-4) +: 8];
        if (a == 8) return exp_data(m_idx);
        if (a >= 12 && a < 16) return m_cnt[8*(a-12) +: 8];
        if (a >= 16 && a - 16 < nm.len()) return 8'(nm[a-16]);
        return 8'd0;
    endfunction

    task automatic model_wr(bit reg_, int a, int sz, logic [7:0] v);
        if (reg_ && a >= 256) return;
        if (a == 0) begin
            m_act = 0;
            if (v < 3) begin
                m_act = 1;
                m_idx = (reg_ ? 3 : 0) + int'(v);
                m_cnt = '0;
            end
        end else if (m_act && a == exp_off(m_idx)) begin
            if ((m_idx % 3) == 1 || (sz == 1 && v == exp_data(m_idx)))
                m_cnt = m_cnt + 1;
        end
    endtask

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic wr(bit reg_, int a, int sz, logic [7:0] v);
        bus_region = reg_; bus_addr = 12'(a); bus_size = 3'(sz); bus_wdata = v;
        bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        model_wr(reg_, a, sz, v);
    endtask

    task automatic rd(bit reg_, int a, int sz, string req);
        logic [7:0] e;
        e = exp_byte(reg_, a, sz);
        bus_region = reg_; bus_addr = 12'(a); bus_size = 3'(sz);
        bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        chk(bus_rdata === e, req, 32'(bus_rdata), 32'(e));
    endtask

    task automatic rd_cnt(bit reg_, string req);
        for (int b = 12; b < 16; b++) rd(reg_, b, 1, req);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #1_600_000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk(bus_rdata === 8'd0, "R1 rdata", 32'(bus_rdata), 0);
        rd(0, 0, 1, "R1");
        rd(0, 1, 1, "R1");
        wr(0, 2048, 1, 8'hFA);
        rd_cnt(0, "R7 no count when idle");

        // R2/R3/R4: select memory test 0
        wr(0, 0, 1, 8'd0);
        for (int a = 0; a < 16; a++) rd(0, a, 1, "R3 header");
        rd(0, 5, 1, "R4 offset high byte 08");
        chk(exp_byte(0, 5, 1) == 8'h08, "R4 model", 32'(exp_byte(0, 5, 1)), 32'h08);
        // R6: exact match rules
        wr(0, 2048, 1, 8'hFA);
        wr(0, 2048, 1, 8'hFB);
        wr(0, 2048, 2, 8'hFA);
        wr(0, 2049, 1, 8'hFA);
        rd_cnt(0, "R6 kind0");
        chk(m_cnt == 1, "R6 model count", m_cnt, 1);
        // R10 / R8: name and length boundary
        for (int a = 16; a < 28; a++) rd(0, a, 1, "R10 name");
        rd(0, 24, 1, "R8 last char");
        rd(0, 24, 2, "R8 size2 past end");
        rd(0, 25, 1, "R8 terminator reads 0");

        // R5: wildcard test
        wr(0, 0, 1, 8'd1);
        rd_cnt(0, "R2 count cleared");
        wr(0, 2049, 4, 8'h00);
        wr(0, 2049, 2, 8'h55);
        wr(0, 2049, 1, 8'hCE);
        rd_cnt(0, "R5 any data");
        chk(m_cnt == 3, "R5 model count", m_cnt, 3);

        // R2/R4/R9: I/O test 2 -> index 5
        wr(1, 0, 1, 8'd2);
        for (int a = 0; a < 9; a++) rd(1, a, 1, "R4 io header");
        wr(1, 133, 1, 8'hFA);
        wr(1, 256 + 133, 1, 8'hFA);
        wr(1, 2048, 1, 8'h00);
        rd(1, 300, 1, "R9 io out of window");
        rd_cnt(1, "R9 io count");
        rd_cnt(0, "R7 shared header via memory");
        wr(0, 133, 1, 8'hFA);
        rd_cnt(1, "R7 match by address");
        for (int a = 16; a < 26; a++) rd(1, a, 1, "R10 io name");

        // R2: invalid test number
        wr(0, 0, 1, 8'd3);
        rd(0, 0, 1, "R2 stop");
        rd(0, 12, 1, "R2 stop");
        wr(1, 0, 1, 8'd1);
        wr(1, 0, 1, 8'hFF);
        rd(1, 1, 1, "R2 stop io");

        // random mix
        for (int k = 0; k < 1500; k++) begin
            bit reg_;
            int a, sz, sel;
            logic [7:0] v;
            reg_ = 1'($urandom_range(0, 1));
            sel  = int'($urandom_range(0, 9));
            case (sel)
                0, 1:    a = 0;
                2, 3, 4: a = m_act ? exp_off(m_idx) : 2048;
                5, 6:    a = int'($urandom_range(0, 30));
                7:       a = int'($urandom_range(250, 262));
                default: a = int'($urandom_range(0, 4095));
            endcase
            case ($urandom_range(0, 2))
                0: sz = 1;
                1: sz = 2;
                default: sz = 4;
            endcase
            if ($urandom_range(0, 3) != 0) sz = 1;
            case ($urandom_range(0, 4))
                0: v = 8'($urandom_range(0, 3));
                1: v = 8'hFA;
                2: v = 8'hCE;
                default: v = 8'($urandom);
            endcase
            if ($urandom_range(0, 1) == 0) wr(reg_, a, sz, v);
            else rd(reg_, a, sz, "R3 R8 random read");
            if ((k % 50) == 0) rd_cnt(reg_, "R11 random count");
        end

        summary();
    end

endmodule